// File: doc/BRIEF.md
# Dual-Line Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and drives two request lines toward a processor core. One is the normal interrupt request and the other is the fast interrupt request. Each line has its own enable mask over the same raw level vector, so software can route any source to either line, to both, or to neither. Sources are treated as pure levels. The block does no latching, no prioritising and no vectoring. A request line stays high for as long as at least one enabled source is high.

Software reaches the block through a small word-addressed register port. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high. The enable masks are never written as whole words. Each mask has a set address and a clear address, and writing ones to either one changes only those bits. This lets independent drivers share the masks without read-modify-write races. A software-owned bit is ORed into the designated source (index 0 by default), so firmware can raise a test interrupt without external stimulus.

Top module: `twin_line_intc`

## Requirements
- R1: After reset both enable masks and the software bit are zero. `irq_o` and `fiq_o` are low, and every readable offset returns zero while all sources are low.
- R2: Word offsets 1 and 9 both read the unmasked level vector, zero-extended to the data width.
- R3: A write to offset 2 ORs the written bits into the normal mask, and a write to offset 10 ORs them into the fast mask. Offsets 2 and 10 read back the normal and fast masks.
- R4: A write to offset 3 clears the written bits of the normal mask, and a write to offset 11 clears them in the fast mask. Bits written as zero keep their value.
- R5: Offset 0 reads level AND normal mask, and offset 8 reads level AND fast mask.
- R6: Writing a 1 in bit 0 at offset 4 sets the software bit, and writing a 1 in bit 0 at offset 5 clears it. All other written bits at these offsets are ignored. A read of offset 4 returns only bit 0 of the level vector, in bit 0, with zeros above.
- R7: `irq_o` is high exactly when (level AND normal mask) is nonzero. It is registered, so it follows a level or mask change one clock edge after that change is visible in the registers.
- R8: `fiq_o` is high exactly when (level AND fast mask) is nonzero, with the same one-edge timing. It is independent of the normal mask.
- R9: Reads of the write-only offsets 3, 5 and 11, and of any unmapped offset, return zero.
- R10: Writes to offsets 0, 1, 8 and 9 change neither mask nor the software bit.
- R11: The effective level of source 0 is the external input OR the software bit. Either one alone makes it high, and clearing the software bit leaves it high while the external input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| reg_addr | input | AW | Word address of the register access |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from `reg_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The masks are built up with overlapping set patterns and then cut down with partial clear patterns. This shows true OR and AND-NOT updates, as opposed to plain overwrites. A source vector with one bit routed only to the normal line and another routed only to the fast line separates the two masked status views. Removing the fast routing while the normal one stays shows that the two lines are independent. The software bit is driven with words that have bit 0 cleared and all other bits set. It is also combined with the external source 0 in every order, which shows that the bit is ignored outside bit 0 and that source 0 is an OR of both. Every output check samples just before and just after the edge where the registered line should change, which catches a combinational or a two-stage path.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // Word offsets decoded by the register port
   localparam int unsigned OFS_IRQ_STAT = 0;
   localparam int unsigned OFS_IRQ_RAW  = 1;
   localparam int unsigned OFS_IRQ_SET  = 2;
   localparam int unsigned OFS_IRQ_CLR  = 3;
   localparam int unsigned OFS_SOFT_SET = 4;
   localparam int unsigned OFS_SOFT_CLR = 5;
   localparam int unsigned OFS_FIQ_STAT = 8;
   localparam int unsigned OFS_FIQ_RAW  = 9;
   localparam int unsigned OFS_FIQ_SET  = 10;
   localparam int unsigned OFS_FIQ_CLR  = 11;

   // Request lines: index 0 normal, index 1 fast
   localparam int unsigned N_CHAN = 2;

   function automatic int unsigned chan_set_ofs(input int unsigned c);
      return (c == 0) ? OFS_IRQ_SET : OFS_FIQ_SET;
   endfunction

   function automatic int unsigned chan_clr_ofs(input int unsigned c);
      return (c == 0) ? OFS_IRQ_CLR : OFS_FIQ_CLR;
   endfunction
endpackage

// File: rtl/intc_src_stage.sv
module intc_src_stage
   import intc_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned SOFT_SRC = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic            wr_i,
   input  logic [AW-1:0]   addr_i,
   input  logic            bit0_i,
   output logic [NSRC-1:0] lvl_o,
   output logic            soft_o
);
   localparam logic [AW-1:0] A_SET = AW'(OFS_SOFT_SET);
   localparam logic [AW-1:0] A_CLR = AW'(OFS_SOFT_CLR);

   logic soft_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= 1'b0;
      end else if (wr_i && bit0_i) begin
         if (addr_i == A_SET) begin
            soft_q <= 1'b1;
         end else if (addr_i == A_CLR) begin
            soft_q <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_lvl
      if (i == SOFT_SRC) begin : g_soft
         assign lvl_o[i] = src_i[i] | soft_q;
      end else begin : g_ext
         assign lvl_o[i] = src_i[i];
      end
   end

   assign soft_o = soft_q;
endmodule

// File: rtl/intc_mask_chan.sv
module intc_mask_chan #(
   parameter int unsigned NSRC    = 32,
   parameter int unsigned AW      = 4,
   parameter int unsigned SET_OFS = 2,
   parameter int unsigned CLR_OFS = 3,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] lvl_i,
   input  logic            wr_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [NSRC-1:0] wbits_i,
   output logic [NSRC-1:0] mask_o,
   output logic [NSRC-1:0] stat_o,
   output logic            line_o
);
   localparam logic [AW-1:0] A_SET = AW'(SET_OFS);
   localparam logic [AW-1:0] A_CLR = AW'(CLR_OFS);

   logic [NSRC-1:0] mask_q;
   logic            any_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_i) begin
         if (addr_i == A_SET) begin
            mask_q <= mask_q | wbits_i;
         end else if (addr_i == A_CLR) begin
            mask_q <= mask_q & ~wbits_i;
         end
      end
   end

   assign stat_o = lvl_i & mask_q;
   assign any_w  = |stat_o;
   assign mask_o = mask_q;

   if (OUT_REG) begin : g_reg_out
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q <= 1'b0;
         end else begin
            line_q <= any_w;
         end
      end
      assign line_o = line_q;
   end else begin : g_comb_out
      assign line_o = any_w;
   end
endmodule

// File: rtl/intc_rd_mux.sv
module intc_rd_mux
   import intc_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned SOFT_SRC = 0
) (
   input  logic [AW-1:0]   addr_i,
   input  logic [NSRC-1:0] lvl_i,
   input  logic [NSRC-1:0] imask_i,
   input  logic [NSRC-1:0] istat_i,
   input  logic [NSRC-1:0] fmask_i,
   input  logic [NSRC-1:0] fstat_i,
   output logic [DW-1:0]   rdata_o
);
   localparam logic [AW-1:0] A_ISTAT = AW'(OFS_IRQ_STAT);
   localparam logic [AW-1:0] A_IRAW  = AW'(OFS_IRQ_RAW);
   localparam logic [AW-1:0] A_ISET  = AW'(OFS_IRQ_SET);
   localparam logic [AW-1:0] A_SOFT  = AW'(OFS_SOFT_SET);
   localparam logic [AW-1:0] A_FSTAT = AW'(OFS_FIQ_STAT);
   localparam logic [AW-1:0] A_FRAW  = AW'(OFS_FIQ_RAW);
   localparam logic [AW-1:0] A_FSET  = AW'(OFS_FIQ_SET);

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_ISTAT:         rdata_o = DW'(istat_i);
         A_IRAW, A_FRAW:  rdata_o = DW'(lvl_i);
         A_ISET:          rdata_o = DW'(imask_i);
         A_SOFT:          rdata_o = DW'(lvl_i[SOFT_SRC]);
         A_FSTAT:         rdata_o = DW'(fstat_i);
         A_FSET:          rdata_o = DW'(fmask_i);
         default:         rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/twin_line_intc.sv
module twin_line_intc
   import intc_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned SOFT_SRC = 0,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic [AW-1:0]   reg_addr,
   input  logic            reg_wr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            irq_o,
   output logic            fiq_o
);
   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("NSRC must lie in 1..DW");
   end
   if (AW < 4) begin : g_bad_aw
      $error("AW must be at least 4 to decode offset 11");
   end
   if (SOFT_SRC >= NSRC) begin : g_bad_soft
      $error("SOFT_SRC must index an existing source");
   end

   logic [NSRC-1:0] lvl;
   logic            soft_q;
   logic [NSRC-1:0] mask_a [N_CHAN];
   logic [NSRC-1:0] stat_a [N_CHAN];
   logic            line_a [N_CHAN];
   logic [NSRC-1:0] irq_mask;
   logic [NSRC-1:0] fiq_mask;

   intc_src_stage #(
      .NSRC(NSRC), .AW(AW), .SOFT_SRC(SOFT_SRC)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_i(reg_wr),
      .addr_i(reg_addr), .bit0_i(reg_wdata[0]),
      .lvl_o(lvl), .soft_o(soft_q)
   );

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      intc_mask_chan #(
         .NSRC(NSRC), .AW(AW),
         .SET_OFS(chan_set_ofs(c)), .CLR_OFS(chan_clr_ofs(c)),
         .OUT_REG(OUT_REG)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .wr_i(reg_wr),
         .addr_i(reg_addr), .wbits_i(reg_wdata[NSRC-1:0]),
         .mask_o(mask_a[c]), .stat_o(stat_a[c]), .line_o(line_a[c])
      );
   end

   assign irq_mask = mask_a[0];
   assign fiq_mask = mask_a[1];
   assign irq_o    = line_a[0];
   assign fiq_o    = line_a[1];

   intc_rd_mux #(
      .NSRC(NSRC), .DW(DW), .AW(AW), .SOFT_SRC(SOFT_SRC)
   ) u_rd (
      .addr_i(reg_addr), .lvl_i(lvl),
      .imask_i(irq_mask), .istat_i(stat_a[0]),
      .fmask_i(fiq_mask), .fstat_i(stat_a[1]),
      .rdata_o(reg_rdata)
   );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int unsigned NSRC     = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned SOFT_SRC = 0,
   parameter bit          OUT_REG  = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] src_i,
   input logic [AW-1:0]   reg_addr,
   input logic            reg_wr,
   input logic [DW-1:0]   reg_wdata,
   input logic [DW-1:0]   reg_rdata,
   input logic            irq_o,
   input logic            fiq_o,
   input logic [NSRC-1:0] lvl,
   input logic [NSRC-1:0] irq_mask,
   input logic [NSRC-1:0] fiq_mask,
   input logic            soft_q
);
   localparam logic [AW-1:0] A_ISTAT = AW'(OFS_IRQ_STAT);
   localparam logic [AW-1:0] A_IRAW  = AW'(OFS_IRQ_RAW);
   localparam logic [AW-1:0] A_ISET  = AW'(OFS_IRQ_SET);
   localparam logic [AW-1:0] A_ICLR  = AW'(OFS_IRQ_CLR);
   localparam logic [AW-1:0] A_SCLR  = AW'(OFS_SOFT_CLR);
   localparam logic [AW-1:0] A_FSTAT = AW'(OFS_FIQ_STAT);
   localparam logic [AW-1:0] A_FRAW  = AW'(OFS_FIQ_RAW);
   localparam logic [AW-1:0] A_FSET  = AW'(OFS_FIQ_SET);
   localparam logic [AW-1:0] A_FCLR  = AW'(OFS_FIQ_CLR);

   logic ro_addr;
   assign ro_addr = (reg_addr == A_ISTAT) || (reg_addr == A_IRAW) ||
                    (reg_addr == A_FSTAT) || (reg_addr == A_FRAW);

   a_r2_raw_read: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_IRAW || reg_addr == A_FRAW) |-> reg_rdata == DW'(lvl));

   a_r3_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ISET) |=>
         irq_mask == ($past(irq_mask) | $past(reg_wdata[NSRC-1:0])));

   a_r3_fiq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_FSET) |=>
         fiq_mask == ($past(fiq_mask) | $past(reg_wdata[NSRC-1:0])));

   a_r4_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_ICLR) |=>
         irq_mask == ($past(irq_mask) & ~$past(reg_wdata[NSRC-1:0])));

   a_r4_fiq_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_FCLR) |=>
         fiq_mask == ($past(fiq_mask) & ~$past(reg_wdata[NSRC-1:0])));

   a_r5_irq_stat: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_ISTAT) |-> reg_rdata == DW'(lvl & irq_mask));

   a_r9_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_ICLR || reg_addr == A_SCLR || reg_addr == A_FCLR)
         |-> reg_rdata == '0);

   a_r10_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ro_addr) |=>
         ($stable(irq_mask) && $stable(fiq_mask) && $stable(soft_q)));

   a_r11_src_or: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[SOFT_SRC] || soft_q) |-> lvl[SOFT_SRC]);

   if (OUT_REG) begin : g_reg_line
      a_r7_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq_o == $past(|(lvl & irq_mask)));
      a_r8_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> fiq_o == $past(|(lvl & fiq_mask)));
   end else begin : g_comb_line
      a_r7_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o == |(lvl & irq_mask));
      a_r8_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
         fiq_o == |(lvl & fiq_mask));
   end
endmodule

bind twin_line_intc intc_chk #(
   .NSRC(NSRC), .DW(DW), .AW(AW), .SOFT_SRC(SOFT_SRC), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .irq_o(irq_o), .fiq_o(fiq_o), .lvl(lvl), .irq_mask(irq_mask),
   .fiq_mask(fiq_mask), .soft_q(soft_q)
);

// File: tb/sim_twin_line_intc.sv
`timescale 1ns/1ps
module sim_twin_line_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;
   logic        fiq_o;

   int n_run  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   twin_line_intc u0 (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic edge_wait();
      @(posedge clk);
      #1;
   endtask

   // R1: reset state
   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         chk("R1", $sformatf("read offset %0d after reset", a), d, 32'h0);
      end
      chk("R1", "irq_o after reset", {31'h0, irq_o}, 32'h0);
      chk("R1", "fiq_o after reset", {31'h0, fiq_o}, 32'h0);
   endtask

   // R3: set ports OR into masks
   task automatic t_enable_set();
      logic [31:0] d;
      wr(4'd2, 32'h0000_00F0);
      wr(4'd2, 32'h0000_0F00);
      rd(4'd2, d); chk("R3", "normal mask after two sets", d, 32'h0000_0FF0);
      wr(4'd10, 32'h8000_0001);
      rd(4'd10, d); chk("R3", "fast mask after set", d, 32'h8000_0001);
      rd(4'd2, d); chk("R3", "normal mask untouched by fast set", d, 32'h0000_0FF0);
   endtask

   // R4: clear ports remove only written bits
   task automatic t_enable_clr();
      logic [31:0] d;
      wr(4'd3, 32'h0000_0030);
      rd(4'd2, d); chk("R4", "normal mask after partial clear", d, 32'h0000_0FC0);
      wr(4'd11, 32'h0000_0001);
      rd(4'd10, d); chk("R4", "fast mask after partial clear", d, 32'h8000_0000);
   endtask

   // R2, R5, R7, R8: raw and masked views, line timing
   task automatic t_levels();
      logic [31:0] d;
      @(negedge clk);
      src_i = 32'h8000_0040;
      #1;
      chk("R7", "irq_o not yet raised before edge", {31'h0, irq_o}, 32'h0);
      chk("R8", "fiq_o not yet raised before edge", {31'h0, fiq_o}, 32'h0);
      edge_wait();
      chk("R7", "irq_o one edge after level", {31'h0, irq_o}, 32'h1);
      chk("R8", "fiq_o one edge after level", {31'h0, fiq_o}, 32'h1);
      rd(4'd1, d); chk("R2", "raw view offset 1", d, 32'h8000_0040);
      rd(4'd9, d); chk("R2", "raw view offset 9", d, 32'h8000_0040);
      rd(4'd0, d); chk("R5", "normal masked status", d, 32'h0000_0040);
      rd(4'd8, d); chk("R5", "fast masked status", d, 32'h8000_0000);
   endtask

   // R8: fast line independent of normal line
   task automatic t_independent();
      wr(4'd11, 32'h8000_0000);
      chk("R8", "fiq_o holds until edge after mask clear", {31'h0, fiq_o}, 32'h1);
      edge_wait();
      chk("R8", "fiq_o low after fast mask cleared", {31'h0, fiq_o}, 32'h0);
      chk("R7", "irq_o stays high", {31'h0, irq_o}, 32'h1);
      @(negedge clk);
      src_i = 32'h0;
      edge_wait();
      chk("R7", "irq_o low after level drops", {31'h0, irq_o}, 32'h0);
   endtask

   // R6: software bit
   task automatic t_soft();
      logic [31:0] d;
      wr(4'd4, 32'hFFFF_FFFE);
      rd(4'd1, d); chk("R6", "set with bit0 clear ignored", d, 32'h0);
      wr(4'd4, 32'h0000_0001);
      rd(4'd4, d); chk("R6", "soft readback after set", d, 32'h1);
      rd(4'd1, d); chk("R6", "raw shows soft bit", d, 32'h1);
      wr(4'd2, 32'h0000_0001);
      edge_wait();
      chk("R7", "irq_o from soft source", {31'h0, irq_o}, 32'h1);
      wr(4'd5, 32'hFFFF_FFFE);
      rd(4'd4, d); chk("R6", "clear with bit0 clear ignored", d, 32'h1);
      wr(4'd5, 32'h0000_0001);
      rd(4'd4, d); chk("R6", "soft readback after clear", d, 32'h0);
      edge_wait();
      chk("R7", "irq_o low after soft clear", {31'h0, irq_o}, 32'h0);
   endtask

   // R11: source 0 is external OR software
   task automatic t_src0_or();
      logic [31:0] d;
      @(negedge clk);
      src_i = 32'h0000_0001;
      rd(4'd4, d); chk("R11", "external alone drives source 0", d, 32'h1);
      rd(4'd0, d); chk("R11", "masked status from external source 0", d, 32'h1);
      wr(4'd4, 32'h1);
      wr(4'd5, 32'h1);
      rd(4'd4, d); chk("R11", "source 0 high after soft clear with external high", d, 32'h1);
      wr(4'd4, 32'h1);
      @(negedge clk);
      src_i = 32'h0;
      rd(4'd4, d); chk("R11", "soft alone drives source 0", d, 32'h1);
      wr(4'd5, 32'h1);
      rd(4'd4, d); chk("R11", "source 0 low with both off", d, 32'h0);
   endtask

   // R9: write-only and unmapped reads
   task automatic t_wo_read();
      logic [31:0] d;
      rd(4'd3,  d); chk("R9", "read offset 3", d, 32'h0);
      rd(4'd5,  d); chk("R9", "read offset 5", d, 32'h0);
      rd(4'd11, d); chk("R9", "read offset 11", d, 32'h0);
      rd(4'd6,  d); chk("R9", "read unmapped 6", d, 32'h0);
      rd(4'd15, d); chk("R9", "read unmapped 15", d, 32'h0);
   endtask

   // R10: writes to status/raw offsets have no effect
   task automatic t_ro_write();
      logic [31:0] d;
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd8, 32'hFFFF_FFFF);
      wr(4'd9, 32'hFFFF_FFFF);
      rd(4'd2,  d); chk("R10", "normal mask unchanged", d, 32'h0000_0FC1);
      rd(4'd10, d); chk("R10", "fast mask unchanged", d, 32'h0);
      rd(4'd4,  d); chk("R10", "soft bit unchanged", d, 32'h0);
      edge_wait();
      chk("R10", "irq_o still low", {31'h0, irq_o}, 32'h0);
   endtask

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_enable_set();
      t_enable_clr();
      t_levels();
      t_independent();
      t_soft();
      t_src0_or();
      t_wo_read();
      t_ro_write();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule